// File: doc/BRIEF.md
# Waveform Pattern-Match Trigger

This block watches one stream of digitized samples and raises a trigger when a short stretch of the waveform takes a programmed shape. Two programmable levels sort every valid sample into one of three classes: high, intermediate or low. The block keeps the classes of the eight most recent valid samples. It compares this window on every sample against a bank of programmable eight-position patterns. Any position of a pattern may require one class or accept any class.

All patterns are evaluated in parallel. A one-cycle trigger pulse is produced when at least one enabled pattern fits the window. The pulse carries the number of the lowest-numbered fitting pattern. Software-side logic loads the two levels and the patterns through a simple write port. Every write restarts the warm-up, so no trigger comes from a window that was classified under an older setup.

Top module: `wave_pattern_trigger`

## Requirements
- R1: A valid sample strictly greater than the high level is classed high. A sample strictly below the low level is classed low. Any other sample, including one exactly equal to either level, is classed intermediate.
- R2: A pattern word is 16 bits, and position p sits in bits [2p+1:2p]. Position 0 applies to the oldest of the last eight valid samples and position 7 to the newest. The position codes are 00 = any class, 01 = low, 10 = intermediate, 11 = high.
- R3: A trigger is a single-cycle pulse on `trig_pulse`. It is high in the clock cycle that follows the rising edge at which the completing valid sample was taken.
- R4: A pattern fits only when its enable bit is set. The enable bit is bit 16 of the configuration word. A pattern whose enable bit is clear never causes a trigger.
- R5: When several enabled patterns fit, `trig_index` reports the lowest pattern number. `trig_index` is 0 whenever `trig_pulse` is low.
- R6: After reset, no trigger is issued until eight valid samples have been taken.
- R7: Every configuration write restarts the count of R6, and eight further valid samples are needed. A sample presented in the same cycle as a write is placed in the window but is not counted, and that cycle cannot trigger.
- R8: Cycles with `smp_valid` low leave the window unchanged, whatever value `smp_data` has, and cannot trigger.
- R9: Write address 0 sets the high level and address 1 sets the low level, both taken from the low 12 bits. Address 2+n sets pattern n. After reset the high level is 4095, the low level is 0, and every pattern is disabled and all-any.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | 12 | Unsigned sample value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration address (0 high level, 1 low level, 2+n pattern n) |
| cfg_wdata | input | 17 | Configuration data: bit 16 enable, bits 15:0 pattern or level |
| trig_pulse | output | 1 | One-cycle trigger |
| trig_index | output | 7 | Lowest fitting pattern number, 0 when idle |

## Verification
Each trigger result is due exactly one clock after the valid sample that completes the window. Configuration writes take effect at the next edge. The bench drives every input on the falling edge and reads the outputs on the following falling edge, which is half a period after the single register stage has updated. Each sample push is therefore checked against its own expected pulse and index before the next sample is presented. Gaps and writes are checked in the same way, one cycle after they are applied.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

    typedef enum logic [1:0] {
        CLS_ANY  = 2'b00,
        CLS_LOW  = 2'b01,
        CLS_MID  = 2'b10,
        CLS_HIGH = 2'b11
    } cls_e;

    localparam int unsigned CODE_W = 2;

endpackage

// File: rtl/wpt_classifier.sv
module wpt_classifier
    import wpt_pkg::*;
#(
    parameter int unsigned SW = 12
) (
    input  logic [SW-1:0] smp,
    input  logic [SW-1:0] lvl_hi,
    input  logic [SW-1:0] lvl_lo,
    output cls_e          cls
);

    always_comb begin
        if (smp > lvl_hi) begin
            cls = CLS_HIGH;
        end else if (smp < lvl_lo) begin
            cls = CLS_LOW;
        end else begin
            cls = CLS_MID;
        end
    end

endmodule

// File: rtl/wpt_pattern_bank.sv
module wpt_pattern_bank #(
    parameter int unsigned NUM_PAT = 72,
    parameter int unsigned WIN     = 8,
    parameter int unsigned AW      = 7,
    parameter int unsigned BASE    = 2,
    localparam int unsigned PW     = 2 * WIN
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [AW-1:0]      addr,
    input  logic [PW:0]        wdata,
    input  logic [PW-1:0]      window,
    output logic [NUM_PAT-1:0] match
);

    for (genvar n = 0; n < NUM_PAT; n++) begin : g_pat
        logic [PW:0] word_d;
        logic [PW:0] word_q;
        logic        fit;

        always_comb begin
            word_d = word_q;
            if (we && (addr == AW'(BASE + n))) begin
                word_d = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                word_q <= word_d;
            end
        end

        always_comb begin
            fit = word_q[PW];
            for (int p = 0; p < WIN; p++) begin
                if ((word_q[2*p +: 2] != 2'b00) &&
                    (word_q[2*p +: 2] != window[2*p +: 2])) begin
                    fit = 1'b0;
                end
            end
        end

        assign match[n] = fit;
    end

endmodule

// File: rtl/wpt_first_hit.sv
module wpt_first_hit #(
    parameter int unsigned N  = 72,
    parameter int unsigned IW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                hit = 1'b1;
                idx = IW'(i);
            end
        end
    end

    assert_hit_points_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> req[idx]);

    assert_single_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(req) == 1) |-> hit);

endmodule

// File: rtl/wave_pattern_trigger.sv
module wave_pattern_trigger
    import wpt_pkg::*;
#(
    parameter int unsigned SW      = 12,
    parameter int unsigned NUM_PAT = 72,
    parameter int unsigned WIN     = 8,
    localparam int unsigned PW     = 2 * WIN,
    localparam int unsigned CW     = (PW + 1 > SW) ? PW + 1 : SW,
    localparam int unsigned AW     = $clog2(NUM_PAT + 2),
    localparam int unsigned IW     = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1,
    localparam int unsigned FW     = $clog2(WIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [SW-1:0] smp_data,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_wdata,
    output logic          trig_pulse,
    output logic [IW-1:0] trig_index
);

    localparam logic [AW-1:0] ADDR_HI = AW'(0);
    localparam logic [AW-1:0] ADDR_LO = AW'(1);
    localparam logic [FW-1:0] FULL    = FW'(WIN);

    typedef struct packed {
        logic [SW-1:0] lvl_hi;
        logic [SW-1:0] lvl_lo;
        logic [PW-1:0] hist;
        logic [FW-1:0] fill;
        logic          trig;
        logic [IW-1:0] idx;
    } state_t;

    state_t st_d;
    state_t st_q;

    cls_e              cls;
    logic [PW-1:0]     hist_nx;
    logic [FW-1:0]     fill_nx;
    logic [NUM_PAT-1:0] fits;
    logic              any_fit;
    logic [IW-1:0]     first_fit;

    wpt_classifier #(.SW(SW)) i_cls (
        .smp    (smp_data),
        .lvl_hi (st_q.lvl_hi),
        .lvl_lo (st_q.lvl_lo),
        .cls    (cls)
    );

    assign hist_nx = smp_valid ? {cls, st_q.hist[PW-1:CODE_W]} : st_q.hist;
    assign fill_nx = (!smp_valid || st_q.fill == FULL) ? st_q.fill : st_q.fill + 1'b1;

    wpt_pattern_bank #(
        .NUM_PAT (NUM_PAT),
        .WIN     (WIN),
        .AW      (AW),
        .BASE    (2)
    ) i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata[PW:0]),
        .window (hist_nx),
        .match  (fits)
    );

    wpt_first_hit #(.N(NUM_PAT), .IW(IW)) i_first (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (fits),
        .hit   (any_fit),
        .idx   (first_fit)
    );

    always_comb begin
        st_d      = st_q;
        st_d.hist = hist_nx;
        st_d.fill = fill_nx;
        st_d.trig = 1'b0;
        st_d.idx  = '0;
        if (cfg_we) begin
            st_d.fill = '0;
            if (cfg_addr == ADDR_HI) begin
                st_d.lvl_hi = cfg_wdata[SW-1:0];
            end
            if (cfg_addr == ADDR_LO) begin
                st_d.lvl_lo = cfg_wdata[SW-1:0];
            end
        end else if (smp_valid && (fill_nx == FULL) && any_fit) begin
            st_d.trig = 1'b1;
            st_d.idx  = first_fit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lvl_hi <= '1;
            st_q.lvl_lo <= '0;
            st_q.hist   <= '0;
            st_q.fill   <= '0;
            st_q.trig   <= 1'b0;
            st_q.idx    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_pulse = st_q.trig;
    assign trig_index = st_q.idx;

    assert_newest_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && (smp_data > st_q.lvl_hi)) |=> (st_q.hist[PW-1 -: 2] == CLS_HIGH));

    assert_pulse_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> ($past(smp_valid) && !$past(cfg_we)));

    assert_warm_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> (st_q.fill == FULL));

    assert_cfg_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (st_q.fill == '0));

    assert_idle_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_pulse |-> (trig_index == '0));

    assert_gap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(st_q.hist));

endmodule

// File: tb/test_wave_pattern_trigger.sv
module test_wave_pattern_trigger;

    localparam int NP = 72;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [16:0] cfg_wdata = '0;
    logic        trig_pulse;
    logic [6:0]  trig_index;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [11:0] VH = 12'd3000;
    localparam logic [11:0] VI = 12'd1500;
    localparam logic [11:0] VL = 12'd500;

    always #4 clk = ~clk;

    wave_pattern_trigger i_wave_pattern_trigger (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .trig_pulse (trig_pulse),
        .trig_index (trig_index)
    );

    function automatic logic [15:0] pat(input string s);
        logic [15:0] w = '0;
        for (int p = 0; p < 8; p++) begin
            case (s[p])
                "H":     w[2*p +: 2] = 2'b11;
                "I":     w[2*p +: 2] = 2'b10;
                "L":     w[2*p +: 2] = 2'b01;
                default: w[2*p +: 2] = 2'b00;
            endcase
        end
        return w;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [16:0] data);
        smp_valid = 1'b0;
        cfg_we    = 1'b1;
        cfg_addr  = 7'(addr);
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic set_pat(input int n, input bit en, input string s);
        wr(2 + n, {en, pat(s)});
    endtask

    task automatic clear_all();
        for (int n = 0; n < NP; n++) begin
            set_pat(n, 1'b0, "XXXXXXXX");
        end
    endtask

    task automatic push(input logic [11:0] d, input bit et, input int ei, input string tag);
        smp_valid = 1'b1;
        smp_data  = d;
        @(negedge clk);
        smp_valid = 1'b0;
        chk({tag, " pulse"}, int'(trig_pulse), int'(et));
        chk({tag, " index"}, int'(trig_index), ei);
    endtask

    task automatic fill7(input logic [11:0] d, input string tag);
        for (int k = 0; k < 7; k++) begin
            push(d, 1'b0, 0, tag);
        end
    endtask

    task automatic t_reset();
        chk("R9 reset pulse", int'(trig_pulse), 0);
        chk("R9 reset index", int'(trig_index), 0);
        set_pat(0, 1'b1, "IIIIIIII");
        fill7(12'd4095, "R9 default levels warmup");
        push(12'd0, 1'b1, 0, "R9 default levels edge");
        push(12'd3000, 1'b1, 0, "R9 default levels mid");
    endtask

    task automatic t_shape();
        clear_all();
        wr(0, 17'd2000);
        wr(1, 17'd1000);
        set_pat(0, 1'b1, "HILXXXXX");
        push(VH, 1'b0, 0, "R2 shape s0");
        push(VI, 1'b0, 0, "R2 shape s1");
        push(VL, 1'b0, 0, "R2 shape s2");
        for (int k = 0; k < 4; k++) push(VI, 1'b0, 0, "R6 shape warmup");
        push(VI, 1'b1, 0, "R3 shape complete");
        push(VI, 1'b0, 0, "R3 single pulse");
        push(VH, 1'b0, 0, "R2 order shifted");
    endtask

    task automatic t_levels();
        clear_all();
        set_pat(4, 1'b1, "XXXXXXXI");
        fill7(VI, "R1 warmup");
        push(12'd2000, 1'b1, 4, "R1 equal high level");
        push(12'd1000, 1'b1, 4, "R1 equal low level");
        push(12'd2001, 1'b0, 0, "R1 above high level");
        push(12'd999, 1'b0, 0, "R1 below low level");
        push(12'd1500, 1'b1, 4, "R1 between levels");
        set_pat(4, 1'b1, "XXXXXXXL");
        fill7(VI, "R1 low warmup");
        push(12'd999, 1'b1, 4, "R1 low class");
    endtask

    task automatic t_disabled();
        clear_all();
        set_pat(2, 1'b0, "XXXXXXXX");
        for (int k = 0; k < 9; k++) push(VI, 1'b0, 0, "R4 disabled pattern");
    endtask

    task automatic t_priority();
        clear_all();
        set_pat(5, 1'b1, "XXXXXXXH");
        set_pat(3, 1'b1, "XXXXXXXH");
        set_pat(10, 1'b1, "XXXXXXXX");
        set_pat(71, 1'b1, "XXXXXXLL");
        fill7(VL, "R6 priority warmup");
        push(VH, 1'b1, 3, "R5 lowest of three");
        push(VL, 1'b1, 10, "R5 only any-pattern");
        push(VL, 1'b1, 10, "R5 lower beats last");
    endtask

    task automatic t_restart();
        clear_all();
        set_pat(7, 1'b1, "XXXXXXXX");
        fill7(VI, "R6 count warmup");
        push(VI, 1'b1, 7, "R6 eighth sample");
        wr(0, 17'd2000);
        chk("R7 write cycle pulse", int'(trig_pulse), 0);
        fill7(VI, "R7 after write");
        push(VI, 1'b1, 7, "R7 eighth after write");
        cfg_we    = 1'b1;
        cfg_addr  = 7'd0;
        cfg_wdata = 17'd2000;
        smp_valid = 1'b1;
        smp_data  = VI;
        @(negedge clk);
        cfg_we    = 1'b0;
        smp_valid = 1'b0;
        chk("R7 sample with write pulse", int'(trig_pulse), 0);
        fill7(VI, "R7 uncounted sample");
        push(VI, 1'b1, 7, "R7 eighth counted");
    endtask

    task automatic t_gaps();
        clear_all();
        set_pat(9, 1'b1, "XXXXXXLH");
        fill7(VI, "R8 warmup");
        push(VL, 1'b0, 0, "R8 low before gap");
        smp_data = VH;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8 gap pulse", int'(trig_pulse), 0);
            smp_data = VI;
        end
        push(VH, 1'b1, 9, "R8 gap ignored");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_shape();
        t_levels();
        t_disabled();
        t_priority();
        t_restart();
        t_gaps();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule